// File: doc/BRIEF.md
# Snoop Response Collector

This block sits beside a snooping bus and gathers the replies that every snooping cache returns for one bus transaction. Each cache drives three reply lines: it holds a copy, it holds a modified copy, and its snoop is still in progress. The block ORs each kind of line across all caches. From the combined result it decides whether main memory may answer the transaction. It also tells the requester whether any other cache kept a copy, so the requester can install a read-miss line as exclusive or as shared.

The block tracks one transaction at a time. It accepts an address phase only while idle. It then waits until the snoop is known to be complete. In the default mode the wait lasts until every cache has released its in-progress line, however many cycles that takes. In the alternative mode the window has a fixed length, and a cache that is still busy when the window ends is flagged as an error. At completion the block pulses a done strobe. In that same cycle exactly one of two memory commands is asserted: go or abort. Memory is aborted when a cache owns a modified copy (that cache supplies the data), when an exclusive read finds a sharer, or when a fixed window overran.

Top module: `snoop_collect`

## Requirements
- R1: After synchronous reset, addr_ready is 1 and snoop_done, final_shared, mem_go, mem_abort, owner_supplies and window_err are all 0.
- R2: A cycle with addr_valid=1 and addr_ready=1 accepts a transaction; addr_excl is sampled only in that cycle. addr_ready is 0 from the next cycle up to, but not including, the snoop_done cycle. addr_valid while addr_ready=0 is ignored: it yields no extra snoop_done and does not change the sampled addr_excl.
- R3: Bit i of rsp_shared, rsp_dirty and rsp_wait belongs to cache i. Each combined flag is the OR over all caches. The shared and dirty flags are sticky over the window: a bit seen high in any window cycle counts, even if it later drops.
- R4: Variable mode (FIXED_MODE=0): call the accept cycle cycle 0. The window starts in cycle 1. snoop_done is high for one cycle, in the cycle after the first window cycle in which every rsp_wait bit is 0.
- R5: Fixed mode (FIXED_MODE=1): snoop_done is high in cycle FIXED_WIN+1 after the accept cycle, whatever rsp_wait does.
- R6: Fixed mode: window_err is 1 in the snoop_done cycle exactly when some rsp_wait bit is 1 in the last window cycle (cycle FIXED_WIN).
- R7: final_shared equals the combined sticky shared flag in the snoop_done cycle, and is 0 in every other cycle.
- R8: If the combined dirty flag is set, the done cycle shows mem_abort=1, owner_supplies=1 and mem_go=0.
- R9: An exclusive read (addr_excl=1) that finds the shared flag set and the dirty flag clear gives mem_abort=1 and owner_supplies=0.
- R10: In every snoop_done cycle exactly one of mem_go and mem_abort is 1; mem_go is 1 when none of the abort causes apply. Outside the done cycle mem_go, mem_abort and owner_supplies are 0.
- R11: window_err=1 forces mem_abort=1 and mem_go=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Address phase present on the bus |
| addr_excl | input | 1 | Address phase is an exclusive (ownership) read |
| addr_ready | output | 1 | Idle; an address phase is accepted this cycle |
| rsp_shared | input | N_CACHES | Per-cache: holds a copy |
| rsp_dirty | input | N_CACHES | Per-cache: holds a modified copy |
| rsp_wait | input | N_CACHES | Per-cache: snoop not yet finished |
| snoop_done | output | 1 | One-cycle completion strobe |
| final_shared | output | 1 | Combined shared result, valid with snoop_done |
| mem_go | output | 1 | Memory may send its reply |
| mem_abort | output | 1 | Memory must not reply |
| owner_supplies | output | 1 | A cache with a modified copy supplies the data |
| window_err | output | 1 | Fixed window ended with a snoop still pending |

## Verification
Every result is registered, so all of them appear together one cycle after the cycle that decides them. In variable mode that is the cycle after the first quiet window cycle, which is two cycles after acceptance at the earliest. In fixed mode it is cycle FIXED_WIN+1. addr_ready falls in the cycle after acceptance. The bench drives inputs and samples outputs on falling edges, and numbers the cycles from the accept cycle, so each measured latency is compared with the exact figure given in R4 or R5. The done-cycle flags are read in the same sample in which snoop_done is first seen.

// File: rtl/snoop_collect_pkg.sv
package snoop_collect_pkg;

    // Combined (OR-ed) reply lines for one cycle
    typedef struct packed {
        logic shared;
        logic dirty;
        logic pending;
    } snoop_lines_t;

    // Command handed to memory in the completion cycle
    typedef struct packed {
        logic go;
        logic abort;
        logic owner;
    } mem_action_t;

    // Memory answers only when no cache owns the line, no exclusive read
    // met a sharer, and the snoop did not overrun a fixed window.
    function automatic mem_action_t resolve(input logic sh, input logic dt,
                                            input logic excl, input logic late);
        mem_action_t a;
        a.owner = dt;
        a.abort = dt | (excl & sh) | late;
        a.go    = ~a.abort;
        return a;
    endfunction

endpackage

// File: rtl/snoop_or_reduce.sv
module snoop_or_reduce
    import snoop_collect_pkg::*;
#(
    parameter int N_CACHES = 4
) (
    input  logic [N_CACHES-1:0] shared_in,
    input  logic [N_CACHES-1:0] dirty_in,
    input  logic [N_CACHES-1:0] wait_in,
    output snoop_lines_t        lines
);
    always_comb begin
        lines.shared  = |shared_in;
        lines.dirty   = |dirty_in;
        lines.pending = |wait_in;
    end
endmodule

// File: rtl/snoop_window.sv
module snoop_window #(
    parameter bit FIXED_MODE = 1'b0,
    parameter int FIXED_WIN  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic pend_any,
    output logic busy,
    output logic finish,
    output logic late
);
    localparam int CW = $clog2(FIXED_WIN + 1);
    localparam logic [CW-1:0] LAST = CW'(FIXED_WIN - 1);

    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == LAST);
    assign finish = busy && (FIXED_MODE ? at_end : !pend_any);
    assign late   = finish && pend_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (finish) busy <= 1'b0;
            if (!at_end) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/snoop_decide.sv
module snoop_decide
    import snoop_collect_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        excl_in,
    input  logic        busy,
    input  logic        finish,
    input  logic        late,
    input  logic        sh_any,
    input  logic        dt_any,
    output logic        done,
    output logic        shared_out,
    output mem_action_t action,
    output logic        err
);
    logic acc_sh, acc_dt, excl_q;
    logic sh_now, dt_now;
    mem_action_t act_now;

    always_comb begin
        sh_now  = acc_sh | sh_any;
        dt_now  = acc_dt | dt_any;
        act_now = resolve(sh_now, dt_now, excl_q, late);
    end

    // Sticky accumulation over the snoop window
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_sh <= 1'b0;
            acc_dt <= 1'b0;
            excl_q <= 1'b0;
        end else if (start) begin
            acc_sh <= 1'b0;
            acc_dt <= 1'b0;
            excl_q <= excl_in;
        end else if (busy) begin
            acc_sh <= sh_now;
            acc_dt <= dt_now;
        end
    end

    // Registered completion outputs, all zero outside the done cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            shared_out <= 1'b0;
            action     <= '0;
            err        <= 1'b0;
        end else begin
            done       <= finish;
            shared_out <= finish & sh_now;
            action     <= finish ? act_now : '0;
            err        <= finish & late;
        end
    end
endmodule

// File: rtl/snoop_collect.sv
module snoop_collect
    import snoop_collect_pkg::*;
#(
    parameter int N_CACHES   = 4,
    parameter bit FIXED_MODE = 1'b0,
    parameter int FIXED_WIN  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                addr_valid,
    input  logic                addr_excl,
    output logic                addr_ready,
    input  logic [N_CACHES-1:0] rsp_shared,
    input  logic [N_CACHES-1:0] rsp_dirty,
    input  logic [N_CACHES-1:0] rsp_wait,
    output logic                snoop_done,
    output logic                final_shared,
    output logic                mem_go,
    output logic                mem_abort,
    output logic                owner_supplies,
    output logic                window_err
);
    snoop_lines_t lines;
    mem_action_t  action;
    logic busy, finish, late, start;

    assign addr_ready = !busy;
    assign start      = addr_valid && !busy;

    snoop_or_reduce #(.N_CACHES(N_CACHES)) u_or (
        .shared_in (rsp_shared),
        .dirty_in  (rsp_dirty),
        .wait_in   (rsp_wait),
        .lines     (lines)
    );

    snoop_window #(.FIXED_MODE(FIXED_MODE), .FIXED_WIN(FIXED_WIN)) u_win (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .pend_any (lines.pending),
        .busy     (busy),
        .finish   (finish),
        .late     (late)
    );

    snoop_decide u_dec (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .excl_in    (addr_excl),
        .busy       (busy),
        .finish     (finish),
        .late       (late),
        .sh_any     (lines.shared),
        .dt_any     (lines.dirty),
        .done       (snoop_done),
        .shared_out (final_shared),
        .action     (action),
        .err        (window_err)
    );

    assign mem_go         = action.go;
    assign mem_abort      = action.abort;
    assign owner_supplies = action.owner;
endmodule

// File: rtl/snoop_collect_chk.sv
module snoop_collect_chk #(
    parameter int N_CACHES   = 4,
    parameter bit FIXED_MODE = 1'b0
) (
    input logic                clk,
    input logic                rst,
    input logic                addr_valid,
    input logic                addr_ready,
    input logic [N_CACHES-1:0] rsp_wait,
    input logic                snoop_done,
    input logic                final_shared,
    input logic                mem_go,
    input logic                mem_abort,
    input logic                owner_supplies,
    input logic                window_err
);
    // R10
    go_xor_abort_chk: assert property (@(posedge clk) disable iff (rst)
        snoop_done |-> (mem_go ^ mem_abort));

    // R10
    quiet_outside_chk: assert property (@(posedge clk) disable iff (rst)
        !snoop_done |-> !(mem_go || mem_abort || owner_supplies || final_shared || window_err));

    // R8
    owner_abort_chk: assert property (@(posedge clk) disable iff (rst)
        owner_supplies |-> (mem_abort && !mem_go));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_ready) |=> (!addr_ready && !snoop_done));

    // R2
    idle_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        snoop_done |-> addr_ready);

    // R4
    quiet_before_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!FIXED_MODE && snoop_done) |-> ($past(rsp_wait) == '0));

    // R11
    late_abort_chk: assert property (@(posedge clk) disable iff (rst)
        window_err |-> (mem_abort && !mem_go));
endmodule

bind snoop_collect snoop_collect_chk #(.N_CACHES(N_CACHES), .FIXED_MODE(FIXED_MODE)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .addr_valid     (addr_valid),
    .addr_ready     (addr_ready),
    .rsp_wait       (rsp_wait),
    .snoop_done     (snoop_done),
    .final_shared   (final_shared),
    .mem_go         (mem_go),
    .mem_abort      (mem_abort),
    .owner_supplies (owner_supplies),
    .window_err     (window_err)
);

// File: tb/snoop_collect_test.sv
module snoop_collect_test;
    localparam int NC = 4;
    localparam int FW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic addr_valid = 1'b0, addr_valid_f = 1'b0, addr_excl = 1'b0;
    logic [NC-1:0] rsp_shared = '0, rsp_dirty = '0, rsp_wait = '0;

    logic addr_ready, snoop_done, final_shared, mem_go, mem_abort, owner_supplies, window_err;
    logic addr_ready_f, snoop_done_f, final_shared_f, mem_go_f, mem_abort_f, owner_supplies_f, window_err_f;

    snoop_collect #(.N_CACHES(NC), .FIXED_MODE(1'b0), .FIXED_WIN(FW)) uut (
        .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr_excl(addr_excl),
        .addr_ready(addr_ready), .rsp_shared(rsp_shared), .rsp_dirty(rsp_dirty),
        .rsp_wait(rsp_wait), .snoop_done(snoop_done), .final_shared(final_shared),
        .mem_go(mem_go), .mem_abort(mem_abort), .owner_supplies(owner_supplies),
        .window_err(window_err));

    snoop_collect #(.N_CACHES(NC), .FIXED_MODE(1'b1), .FIXED_WIN(FW)) uut_fixed (
        .clk(clk), .rst(rst), .addr_valid(addr_valid_f), .addr_excl(addr_excl),
        .addr_ready(addr_ready_f), .rsp_shared(rsp_shared), .rsp_dirty(rsp_dirty),
        .rsp_wait(rsp_wait), .snoop_done(snoop_done_f), .final_shared(final_shared_f),
        .mem_go(mem_go_f), .mem_abort(mem_abort_f), .owner_supplies(owner_supplies_f),
        .window_err(window_err_f));

    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic       excl;
        logic [3:0] sh;
        logic [3:0] dt;
        logic [2:0] wt;
        logic       e_sh;
        logic       e_go;
        logic       e_ab;
        logic       e_own;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 4'b0000, 4'b0000, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 4'b0010, 4'b0000, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b1, 4'b0000, 4'b0000, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 4'b1000, 4'b0000, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 4'b0000, 4'b0100, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b1, 4'b0101, 4'b0001, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b0, 4'b1111, 4'b0000, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b1, 4'b0000, 4'b1000, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    // One transaction; cycle 0 is the accept cycle. lat is the cycle number
    // in which snoop_done is first seen.
    task automatic run_tx(input bit use_fixed, input bit excl,
                          input logic [3:0] sh_first, input logic [3:0] sh_rest,
                          input logic [3:0] dt, input logic [3:0] wmask, input int wt,
                          input bit poke, output int lat,
                          output logic o_sh, output logic o_go, output logic o_ab,
                          output logic o_own, output logic o_err, output logic o_ready1);
        lat = -1; o_sh = 0; o_go = 0; o_ab = 0; o_own = 0; o_err = 0; o_ready1 = 1;
        @(negedge clk);
        if (use_fixed) addr_valid_f = 1'b1; else addr_valid = 1'b1;
        addr_excl = excl; rsp_shared = '0; rsp_dirty = '0; rsp_wait = '0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (k == 1) o_ready1 = use_fixed ? addr_ready_f : addr_ready;
            if (use_fixed ? snoop_done_f : snoop_done) begin
                lat = k;
                o_sh  = use_fixed ? final_shared_f   : final_shared;
                o_go  = use_fixed ? mem_go_f         : mem_go;
                o_ab  = use_fixed ? mem_abort_f      : mem_abort;
                o_own = use_fixed ? owner_supplies_f : owner_supplies;
                o_err = use_fixed ? window_err_f     : window_err;
                break;
            end
            addr_valid = 1'b0; addr_valid_f = 1'b0; addr_excl = 1'b0;
            if (poke && k == 2) begin addr_valid = 1'b1; addr_excl = 1'b1; end
            rsp_shared = (k == 1) ? sh_first : sh_rest;
            rsp_dirty  = dt;
            rsp_wait   = (k <= wt) ? wmask : 4'b0000;
        end
        addr_valid = 1'b0; addr_valid_f = 1'b0; addr_excl = 1'b0;
        rsp_shared = '0; rsp_dirty = '0; rsp_wait = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int lat;
        logic s, g, a, o, e, r;
        int extra;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(addr_ready == 1, "R1 addr_ready", addr_ready, 1);
        chk(addr_ready_f == 1, "R1 addr_ready fixed", addr_ready_f, 1);
        chk({snoop_done, final_shared, mem_go, mem_abort, owner_supplies, window_err} == 0,
            "R1 outputs idle", {snoop_done, final_shared, mem_go, mem_abort, owner_supplies, window_err}, 0);
        chk({snoop_done_f, mem_go_f, mem_abort_f, window_err_f} == 0,
            "R1 fixed outputs idle", {snoop_done_f, mem_go_f, mem_abort_f, window_err_f}, 0);

        // Table of vectors, variable mode
        for (int i = 0; i < 8; i++) begin
            run_tx(1'b0, VECS[i].excl, VECS[i].sh, VECS[i].sh, VECS[i].dt,
                   4'b0001 << (i % 4), int'(VECS[i].wt), 1'b0, lat, s, g, a, o, e, r);
            chk(lat == int'(VECS[i].wt) + 2, "R4 done latency", lat, int'(VECS[i].wt) + 2);
            chk(r == 0, "R2 ready low in window", r, 0);
            chk(s == VECS[i].e_sh, "R3 R7 final_shared", s, VECS[i].e_sh);
            chk(g == VECS[i].e_go, "R8 R9 R10 mem_go", g, VECS[i].e_go);
            chk(a == VECS[i].e_ab, "R8 R9 R10 mem_abort", a, VECS[i].e_ab);
            chk(o == VECS[i].e_own, "R8 owner_supplies", o, VECS[i].e_own);
        end

        // R3 sticky shared: only in window cycle 1, exclusive read -> abort (R9)
        run_tx(1'b0, 1'b1, 4'b0100, 4'b0000, 4'b0000, 4'b0010, 2, 1'b0, lat, s, g, a, o, e, r);
        chk(lat == 4, "R4 sticky latency", lat, 4);
        chk(s == 1, "R3 sticky shared", s, 1);
        chk(a == 1 && o == 0, "R9 excl with sharer aborts", {a, o}, 2);

        // R2 address during window ignored
        run_tx(1'b0, 1'b0, 4'b0001, 4'b0001, 4'b0000, 4'b1000, 3, 1'b1, lat, s, g, a, o, e, r);
        chk(lat == 5, "R2 latency with stray address", lat, 5);
        chk(g == 1 && a == 0, "R2 stray excl ignored", {g, a}, 2);
        extra = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (snoop_done) extra++;
        end
        chk(extra == 0, "R2 no extra done", extra, 0);
        chk(addr_ready == 1, "R2 ready after done", addr_ready, 1);

        // Fixed mode
        run_tx(1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 1'b0, lat, s, g, a, o, e, r);
        chk(lat == FW + 1, "R5 fixed latency quiet", lat, FW + 1);
        chk(e == 0 && g == 1, "R6 no error when quiet", {e, g}, 1);

        run_tx(1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 5, 1'b0, lat, s, g, a, o, e, r);
        chk(lat == FW + 1, "R5 fixed latency ignores wait", lat, FW + 1);
        chk(e == 1, "R6 overrun flagged", e, 1);
        chk(a == 1 && g == 0, "R11 overrun aborts memory", {a, g}, 2);

        run_tx(1'b1, 1'b0, 4'b1000, 4'b1000, 4'b0000, 4'b0100, FW - 1, 1'b0, lat, s, g, a, o, e, r);
        chk(lat == FW + 1, "R5 fixed latency late release", lat, FW + 1);
        chk(e == 0, "R6 release in last cycle no error", e, 0);
        chk(s == 1 && g == 1, "R7 fixed shared and go", {s, g}, 3);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule